// File: doc/BRIEF.md
# Log-Depth Zero Counter

This unit reports how many zero bits come before the first set bit of a WIDTH-bit word. The count starts either at the most significant end (leading zeros) or at the least significant end (trailing zeros). It is purely combinational: the count follows the input in the same cycle, with no clock and no state.

Two compile-time parameters choose the behaviour. The first fixes the end of the word that is counted from. The second picks the output encoding:

- **Full encoding** is wide enough to report WIDTH itself.
- **Short encoding** drops that value to save a bit. Its result for an all-zero word is left undefined.

The count is built by a tree that repeatedly splits the word in half, so its depth grows with log2 of the width. For widths that are not a power of two, the word is widened to the next power of two and the count is corrected afterwards.

Top module: `zero_count`

## Requirements
- R1: With ANCHOR set to the most-significant end, the output equals the number of zero bits above the highest set bit of data_in. If bit WIDTH-1 is set the output is 0, and if only bit 0 is set it is WIDTH-1.
- R2: With ANCHOR set to the least-significant end, the output equals the number of zero bits below the lowest set bit. If bit 0 is set the output is 0, and if only bit WIDTH-1 is set it is WIDTH-1.
- R3: The full encoding is clog2(WIDTH+1) bits wide. It outputs exactly WIDTH for an all-zero input, and a value below WIDTH for any nonzero input.
- R4: The short encoding is clog2(WIDTH) bits wide. For every nonzero input it gives the same count as the full encoding; for an all-zero input its value is unspecified.
- R5: A WIDTH that is not a power of two (for example 5, 12 or 24) gives the same results as in R1 to R4. This is done by widening the word with zeros on the counted side to the next power of two, then subtracting the number of added bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_in | input | WIDTH | Word whose leading or trailing zeros are counted |
| zcount_out | output | clog2(WIDTH+1) in full encoding, clog2(WIDTH) in short encoding | Zero count |

## Verification
Assertions inside the design check the following whenever the input changes:

- Each node of the halving tree points at a set bit, with only zeros ahead of it.
- An all-zero node reports a count of all ones.
- The corrected count never exceeds WIDTH.
- In full encoding, an all-zero word gives exactly WIDTH.

Only the bench scenarios can show that the numeric result matches the plain bit-by-bit definition. They cover every input at widths 4, 8, 12 and 16, and walking and randomized patterns at widths 24, 32 and 64. The trailing-zero mirror and the short encoding's agreement on nonzero words are also shown only by the bench.

// File: rtl/zc_pkg.sv
// Shared types and width helpers for the zero counter.
package zc_pkg;

    // Which end of the word the count starts from.
    typedef enum logic {
        ANCHOR_MSB = 1'b0,
        ANCHOR_LSB = 1'b1
    } zc_anchor_e;

    // Output encoding: short drops the all-zero value WIDTH.
    typedef enum logic {
        ENC_SHORT = 1'b0,
        ENC_FULL  = 1'b1
    } zc_enc_e;

    // Output width for a given data width and encoding.
    function automatic int zc_out_w(input int width, input zc_enc_e enc);
        return (enc == ENC_FULL) ? $clog2(width + 1) : $clog2(width);
    endfunction

    // Next power of two at or above width.
    function automatic int zc_pow2(input int width);
        return 1 << $clog2(width);
    endfunction

endpackage

// File: rtl/zc_orient.sv
// Places the counted end of the word at the MSB.
// In LSB mode the bits are mirrored, so the downstream tree only ever
// counts leading zeros. Assumes W >= 1.
module zc_orient
    import zc_pkg::*;
#(
    parameter int         W      = 8,
    parameter zc_anchor_e ANCHOR = ANCHOR_MSB
) (
    input  logic [W-1:0] vec_in,
    output logic [W-1:0] vec_out
);

    generate
        if (ANCHOR == ANCHOR_LSB) begin : g_mirror
            // Bit i of the output is bit W-1-i of the input.
            for (genvar i = 0; i < W; i++) begin : g_bit
                assign vec_out[i] = vec_in[W-1-i];
            end
        end else begin : g_pass
            // Already MSB-anchored; pass straight through.
            assign vec_out = vec_in;
        end
    endgenerate

endmodule

// File: rtl/zc_halve_tree.sv
// Recursive halving leading-zero network over a power-of-two width P.
//
// Each node takes (all_zero, count) from its upper and lower halves and
// forms:
//   all_zero = upper_zero & lower_zero
//   count    = {upper_zero, upper_zero ? lower_count : upper_count}
// The leaf handles two bits. An all-zero vector yields a count of all ones.
// Assumes P is a power of two and at least 2.
module zc_halve_tree #(
    parameter int P = 8,
    localparam int LG = $clog2(P)
) (
    input  logic [P-1:0]  vec,
    output logic          all_zero,
    output logic [LG-1:0] cnt
);

    generate
        if (P == 2) begin : g_leaf
            // Two-bit leaf: the count is 1 unless the upper bit is set.
            assign all_zero = ~(vec[1] | vec[0]);
            assign cnt      = ~vec[1];
        end else begin : g_node
            localparam int H = P / 2;

            logic          hi_zero;
            logic          lo_zero;
            logic [LG-2:0] hi_cnt;
            logic [LG-2:0] lo_cnt;

            zc_halve_tree #(.P(H)) u_hi (
                .vec      (vec[P-1:H]),
                .all_zero (hi_zero),
                .cnt      (hi_cnt)
            );

            zc_halve_tree #(.P(H)) u_lo (
                .vec      (vec[H-1:0]),
                .all_zero (lo_zero),
                .cnt      (lo_cnt)
            );

            // Upper-half flag is the count MSB and steers the lower-bit mux.
            assign cnt      = {hi_zero, (hi_zero ? lo_cnt : hi_cnt)};
            assign all_zero = hi_zero & lo_zero;
        end
    endgenerate

    // Node-level checks on the count this node reports.
    always_comb begin : node_chk
        if (!all_zero) begin
            // R1: the reported bit is set and every bit above it is clear.
            p_first_one_r1: assert (vec[P-1-int'(cnt)] &&
                                    ((vec >> (P - int'(cnt))) == '0))
                else $error("tree node count does not mark the first set bit");
        end else begin
            // R3: an empty node reports all ones and really is empty.
            p_empty_ones_r3: assert ((cnt == '1) && (vec == '0))
                else $error("empty node count is not all ones");
        end
    end

endmodule

// File: rtl/zc_fixup.sv
// Converts the power-of-two tree result into the requested encoding.
//
// PAD zero bits were prepended on the counted side, so PAD is subtracted.
// When PAD is 0 no subtractor is built: the full encoding just prefixes
// the empty flag. Assumes WIDTH <= P < 2*WIDTH.
module zc_fixup
    import zc_pkg::*;
#(
    parameter int      WIDTH = 8,
    parameter zc_enc_e ENC   = ENC_FULL,
    localparam int P   = zc_pow2(WIDTH),
    localparam int LG  = $clog2(P),
    localparam int OW  = zc_out_w(WIDTH, ENC),
    localparam int PAD = P - WIDTH
) (
    input  logic          all_zero,
    input  logic [LG-1:0] cnt,
    output logic [OW-1:0] res
);

    generate
        if (PAD == 0) begin : g_exact
            if (ENC == ENC_FULL) begin : g_full
                // An empty word becomes P: a 1 above LG zeros.
                assign res = {all_zero, (cnt & {LG{~all_zero}})};
            end else begin : g_short
                // Short encoding passes the tree count through unchanged.
                assign res = cnt;
            end
        end else begin : g_pad
            logic [LG:0] ext;
            logic [LG:0] diff;

            // Widen to P on empty input, then remove the padded zeros.
            assign ext  = all_zero ? (LG+1)'(P) : {1'b0, cnt};
            assign diff = ext - (LG+1)'(PAD);
            assign res  = diff[OW-1:0];

            // The corrected count never exceeds WIDTH.
            always_comb begin : pad_chk
                p_bound_r5: assert (int'(diff) <= WIDTH)
                    else $error("corrected count exceeds the width");
            end
        end
    endgenerate

    // An empty word yields WIDTH in full encoding.
    always_comb begin : enc_chk
        if (all_zero && ENC == ENC_FULL) begin
            p_empty_full_r3: assert (int'(res) == WIDTH)
                else $error("full encoding of an empty word is not WIDTH");
        end
    end

endmodule

// File: rtl/zero_count.sv
// Top of the log-depth leading/trailing zero counter.
//
// The word is first oriented so the counted end sits at the MSB. It is then
// zero-extended on that side to a power of two P, fed to the halving tree,
// and the result is corrected and encoded. Fully combinational; assumes
// WIDTH >= 4.
module zero_count
    import zc_pkg::*;
#(
    parameter int         WIDTH  = 16,
    parameter zc_anchor_e ANCHOR = ANCHOR_MSB,
    parameter zc_enc_e    ENC    = ENC_FULL
) (
    input  logic [WIDTH-1:0]                  data_in,
    output logic [zc_out_w(WIDTH, ENC)-1:0]   zcount_out
);

    localparam int P  = zc_pow2(WIDTH);
    localparam int LG = $clog2(P);

    logic [WIDTH-1:0] oriented;
    logic [P-1:0]     padded;
    logic             tree_zero;
    logic [LG-1:0]    tree_cnt;

    zc_orient #(.W(WIDTH), .ANCHOR(ANCHOR)) u_orient (
        .vec_in  (data_in),
        .vec_out (oriented)
    );

    // Zero-extend on the counted (upper) side up to the tree width.
    assign padded = P'(oriented);

    zc_halve_tree #(.P(P)) u_tree (
        .vec      (padded),
        .all_zero (tree_zero),
        .cnt      (tree_cnt)
    );

    zc_fixup #(.WIDTH(WIDTH), .ENC(ENC)) u_fixup (
        .all_zero (tree_zero),
        .cnt      (tree_cnt),
        .res      (zcount_out)
    );

    // Port-level checks in the full encoding.
    always_comb begin : top_chk
        if (ENC == ENC_FULL) begin
            // R3: WIDTH is reported exactly when the word is all zero.
            p_zero_full_r3: assert ((data_in == '0) == (int'(zcount_out) == WIDTH))
                else $error("full count of WIDTH does not match an empty word");
        end
    end

endmodule

// File: tb/tb_zero_count.sv
// Self-checking bench. Runs many configurations side by side, all fed by
// one stimulus bus and compared against a bit-by-bit loop reference.
module tb_zero_count;
    import zc_pkg::*;

    localparam int NCFG = 8;
    localparam int WLIST [NCFG] = '{4, 8, 16, 32, 64, 5, 12, 24};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        checking = 1'b0;
    logic        done = 1'b0;
    logic [63:0] stim = '0;
    int          n_cmp = 0;
    int          n_bad = 0;

    always #4 clk = ~clk;

    // Reference: zeros before the first set bit, or w if none.
    function automatic int ref_cnt(input logic [63:0] v, input int w, input bit lsb);
        for (int i = 0; i < w; i++) begin
            if (v[lsb ? i : (w - 1 - i)]) return i;
        end
        return w;
    endfunction

    for (genvar wi = 0; wi < NCFG; wi++) begin : g_w
        for (genvar a = 0; a < 2; a++) begin : g_a
            for (genvar f = 0; f < 2; f++) begin : g_f
                localparam int      W   = WLIST[wi];
                localparam zc_enc_e E   = (f == 1) ? ENC_FULL : ENC_SHORT;
                localparam int      OW  = zc_out_w(W, E);
                localparam bit      PW2 = ((W & (W - 1)) == 0);

                logic [OW-1:0] res;

                zero_count #(
                    .WIDTH  (W),
                    .ANCHOR ((a == 1) ? ANCHOR_LSB : ANCHOR_MSB),
                    .ENC    (E)
                ) dut (
                    .data_in    (stim[W-1:0]),
                    .zcount_out (res)
                );

                always @(negedge clk) begin
                    if (checking) begin
                        int    e;
                        string tag;
                        e = ref_cnt(stim, W, (a == 1));
                        // Tag priority: R5 odd widths, R3 empty full, R4 short,
                        // then R2 trailing or R1 leading.
                        if (!PW2)          tag = "R5";
                        else if (e == W)   tag = "R3";
                        else if (f == 0)   tag = "R4";
                        else if (a == 1)   tag = "R2";
                        else               tag = "R1";
                        // Short encoding leaves the empty word unspecified (R4).
                        if (f == 1 || e != W) begin
                            n_cmp++;
                            if (res != OW'(e)) begin
                                n_bad++;
                                $display("FAIL %s W=%0d lsb=%0d full=%0d in=%h got %0d exp %0d",
                                         tag, W, a, f, stim, res, e);
                            end
                        end
                    end
                end
            end
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog R1 got timeout exp completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [63:0] r;
        int          sh;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        rst_n    <= 1'b1;
        checking <= 1'b1;
        // Exhaustive over 16 bits: covers every input at W = 4, 8, 12 and 16,
        // including MSB-only, LSB-only and zero (R1 R2 R3 R4 R5).
        for (int i = 0; i < 65536; i++) begin
            @(posedge clk);
            stim <= 64'(i);
        end
        // Walking one, and ones filling from either end.
        for (int p = 0; p < 64; p++) begin
            @(posedge clk); stim <= 64'd1 << p;
            @(posedge clk); stim <= ~64'd0 << p;
            @(posedge clk); stim <= ~64'd0 >> p;
        end
        // Directed corners at full width.
        @(posedge clk); stim <= '0;
        @(posedge clk); stim <= ~64'd0;
        @(posedge clk); stim <= 64'h8000_0000_0000_0000;
        @(posedge clk); stim <= 64'h0000_0000_0000_0001;
        // Randomized words with long zero runs at either end.
        for (int k = 0; k < 3000; k++) begin
            @(posedge clk);
            r  = {$urandom, $urandom};
            sh = int'($urandom % 64);
            if ($urandom % 2 == 0) stim <= r >> sh;
            else                   stim <= r << sh;
        end
        @(posedge clk);
        @(negedge clk);
        @(posedge clk);
        checking <= 1'b0;
        done     <= 1'b1;
        @(negedge clk);
        summary();
        $finish;
    end

endmodule